// File: doc/BRIEF.md
# Mask-Match Memory Bank Decoder

This block holds four programmable bank decode entries and, for each lookup, tells which bank claims a physical address. Each entry has an enable bit and two compare fields. An upper field covers address bits [41:30] and a lower field covers address bits [9:6]. Each field has a match value and a don't-care mask. A bank claims an address when it is enabled and, in both fields, every address bit that differs from the match value is marked don't-care. When several banks claim the same address, the lowest-numbered one wins.

For the winning bank the block also reports properties derived from its programmed masks:
- a base address;
- an interleave factor decoded from the lower don't-care mask;
- a bank size;
- a global bank id built from the controller's port number and the local bank number.

Entries are written one at a time through a simple write strobe. A lookup is requested with a one-cycle pulse, and its result is presented one clock later with a done flag. The control is a two-state machine:
- **IDLE** moves to **SHOW** on a request (transition *capture*).
- **SHOW** moves to **SHOW** on a request (transition *capture*).
- **SHOW** moves back to **IDLE** without a request (transition *retire*).
- **IDLE** stays in **IDLE** without a request (transition *idle*).

Top module: `bank_decoder`

## Requirements
- R1: After reset all four entries are cleared, so every bank is disabled, `lk_done` is 0 and any lookup misses.
- R2: A write with `cfg_we`=1 stores `cfg_data` into entry `cfg_sel`. The `cfg_data` bit positions are: enable bit [32], upper don't-care [31:20], upper match [19:8], lower don't-care [7:4], lower match [3:0]. The new value is used by every lookup requested in a later cycle.
- R3: A disabled entry never claims an address, even when its fields would match.
- R4: Upper field: an entry claims only if every bit where address bits [41:30] differ from the upper match value is set in the upper don't-care mask.
- R5: Lower field: the same rule applies to address bits [9:6], using the lower match value and the lower don't-care mask.
- R6: When several entries claim an address, `lk_bank` reports the lowest index.
- R7: When no entry claims the address, `lk_hit` is 0 and `lk_bank`, `lk_gid`, `lk_base`, `lk_ilv` and `lk_size` are all 0.
- R8: `lk_ilv` is decoded from the lower don't-care mask as follows. Any other mask value gives 1.

  | Lower don't-care mask | `lk_ilv` |
  |---|---|
  | 0x0 | 16 |
  | 0x8 | 8 |
  | 0xC | 4 |
  | 0xE | 2 |
  | 0xF | 1 |

- R9: `lk_base` equals (upper match AND NOT upper don't-care) shifted left by 30.
- R10: `lk_size` equals ((upper don't-care bits [9:0]) + 1) shifted left by 30, divided by `lk_ilv`. Upper don't-care bits 10 and 11 have no effect on the size.
- R11: `lk_gid` equals 4 × `port_id` + `lk_bank`, using the `port_id` sampled with the request.
- R12: `lk_done` is high exactly in the cycle after a cycle with `lk_req` high. All lookup outputs hold until the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Entry write strobe |
| cfg_sel | input | 2 | Entry index to write |
| cfg_data | input | 33 | Entry value: enable, upper don't-care, upper match, lower don't-care, lower match |
| port_id | input | 5 | Controller port number |
| lk_req | input | 1 | Lookup request pulse |
| lk_addr | input | 42 | Physical address to decode |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Some bank claimed the address |
| lk_bank | output | 2 | Local index of the winning bank |
| lk_gid | output | 7 | Global bank id |
| lk_base | output | 42 | Base address of the winning bank |
| lk_ilv | output | 5 | Interleave factor of the winning bank |
| lk_size | output | 42 | Size of the winning bank in bytes |

## Verification
Every lookup result is registered once, so all result ports and `lk_done` change at the rising edge that samples `lk_req`. They are due one cycle after the request. The bench drives each request on a falling edge and samples the results on the following falling edge, which lies half a cycle after that register update. Entry writes are likewise issued and completed a full cycle before any lookup that depends on them, so the bench's expected values always reflect the updated entries.

// File: rtl/bank_dec_pkg.sv
package bank_dec_pkg;
    localparam int UP_W    = 12;
    localparam int UP_POS  = 30;
    localparam int LO_W    = 4;
    localparam int LO_POS  = 6;
    localparam int PA_W    = 42;
    localparam int SZ_KEEP = 10;
    localparam int NBANK   = 4;
    localparam int IDX_W   = $clog2(NBANK);
    localparam int ILV_LW  = $clog2(LO_W + 1);

    typedef struct packed {
        logic            en;
        logic [UP_W-1:0] up_dc;
        logic [UP_W-1:0] up_val;
        logic [LO_W-1:0] lo_dc;
        logic [LO_W-1:0] lo_val;
    } dec_entry_t;

    localparam int ENTRY_W = $bits(dec_entry_t);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } lk_state_t;
endpackage

// File: rtl/bank_entry_store.sv
module bank_entry_store
    import bank_dec_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [IDX_W-1:0]     sel,
    input  dec_entry_t           wdata,
    output dec_entry_t           entries [NBANK]
);
    for (genvar b = 0; b < NBANK; b++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n)
                entries[b] <= '0;
            else if (we && sel == IDX_W'(b))
                entries[b] <= wdata;
        end
    end
endmodule

// File: rtl/bank_field_match.sv
module bank_field_match
    import bank_dec_pkg::*;
(
    input  dec_entry_t      entry,
    input  logic [PA_W-1:0] addr,
    output logic            claim
);
    logic [UP_W-1:0] up_bits;
    logic [LO_W-1:0] lo_bits;
    logic            up_ok;
    logic            lo_ok;

    always_comb begin
        up_bits = addr[UP_POS +: UP_W];
        lo_bits = addr[LO_POS +: LO_W];
        up_ok   = ((up_bits ^ entry.up_val) & ~entry.up_dc) == '0;
        lo_ok   = ((lo_bits ^ entry.lo_val) & ~entry.lo_dc) == '0;
        claim   = entry.en && up_ok && lo_ok;
    end
endmodule

// File: rtl/bank_geometry.sv
module bank_geometry
    import bank_dec_pkg::*;
(
    input  dec_entry_t        entry,
    output logic [PA_W-1:0]   base,
    output logic [ILV_LW-1:0] ilv_log,
    output logic [PA_W-1:0]   size
);
    logic [LO_W-1:0]  pat;
    logic             found;
    logic [PA_W-1:0]  span;

    always_comb begin
        ilv_log = '0;
        found   = 1'b0;
        for (int k = 0; k <= LO_W; k++) begin
            pat = LO_W'({LO_W{1'b1}} << k);
            if (!found && entry.lo_dc == pat) begin
                ilv_log = ILV_LW'(k);
                found   = 1'b1;
            end
        end
        base = PA_W'(entry.up_val & ~entry.up_dc) << UP_POS;
        span = (PA_W'(entry.up_dc[SZ_KEEP-1:0]) + PA_W'(1)) << UP_POS;
        size = span >> ilv_log;
    end
endmodule

// File: rtl/bank_decoder.sv
module bank_decoder
    import bank_dec_pkg::*;
#(
    parameter int PORT_W = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [IDX_W-1:0]        cfg_sel,
    input  logic [ENTRY_W-1:0]      cfg_data,
    input  logic [PORT_W-1:0]       port_id,
    input  logic                    lk_req,
    input  logic [PA_W-1:0]         lk_addr,
    output logic                    lk_done,
    output logic                    lk_hit,
    output logic [IDX_W-1:0]        lk_bank,
    output logic [PORT_W+IDX_W-1:0] lk_gid,
    output logic [PA_W-1:0]         lk_base,
    output logic [LO_W:0]           lk_ilv,
    output logic [PA_W-1:0]         lk_size
);
    dec_entry_t        entries [NBANK];
    logic [NBANK-1:0]  claims;
    logic              any_claim;
    logic [IDX_W-1:0]  win_idx;
    dec_entry_t        win_entry;
    logic [PA_W-1:0]   win_base;
    logic [ILV_LW-1:0] win_ilv_log;
    logic [PA_W-1:0]   win_size;
    lk_state_t         state_q, state_d;

    bank_entry_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .sel     (cfg_sel),
        .wdata   (dec_entry_t'(cfg_data)),
        .entries (entries)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_match
        bank_field_match u_match (
            .entry (entries[b]),
            .addr  (lk_addr),
            .claim (claims[b])
        );
    end

    always_comb begin
        win_idx   = '0;
        any_claim = 1'b0;
        for (int b = NBANK - 1; b >= 0; b--) begin
            if (claims[b]) begin
                win_idx   = IDX_W'(b);
                any_claim = 1'b1;
            end
        end
        win_entry = entries[win_idx];
    end

    bank_geometry u_geom (
        .entry   (win_entry),
        .base    (win_base),
        .ilv_log (win_ilv_log),
        .size    (win_size)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = lk_req ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_d = lk_req ? ST_SHOW : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_hit  <= 1'b0;
            lk_bank <= '0;
            lk_gid  <= '0;
            lk_base <= '0;
            lk_ilv  <= '0;
            lk_size <= '0;
        end else if (lk_req) begin
            lk_hit  <= any_claim;
            lk_bank <= any_claim ? win_idx : '0;
            lk_gid  <= any_claim ? {port_id, win_idx} : '0;
            lk_base <= any_claim ? win_base : '0;
            lk_ilv  <= any_claim ? (LO_W+1)'(1) << win_ilv_log : '0;
            lk_size <= any_claim ? win_size : '0;
        end
    end

    assign lk_done = (state_q == ST_SHOW);
endmodule

// File: rtl/bank_decoder_chk.sv
module bank_decoder_chk
    import bank_dec_pkg::*;
#(
    parameter int PORT_W = 5
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [PORT_W-1:0]       port_id,
    input logic                    lk_req,
    input logic                    lk_done,
    input logic                    lk_hit,
    input logic [IDX_W-1:0]        lk_bank,
    input logic [PORT_W+IDX_W-1:0] lk_gid,
    input logic [PA_W-1:0]         lk_base,
    input logic [LO_W:0]           lk_ilv,
    input logic [PA_W-1:0]         lk_size
);
    // R12: result follows a request by one cycle
    a_r12_done_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> lk_done);
    // R12: no result without a request
    a_r12_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !lk_done);
    // R12: outputs hold between requests
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> $stable(lk_hit) && $stable(lk_base) && $stable(lk_size));
    // R7: a miss reports all-zero properties
    a_r7_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_done && !lk_hit) |-> (lk_bank == '0 && lk_gid == '0 &&
                                  lk_base == '0 && lk_ilv == '0 && lk_size == '0));
    // R8: interleave factor is a power of two on a hit
    a_r8_ilv_pow2: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_done && lk_hit) |-> $countones(lk_ilv) == 1);
    // R11: global id combines the sampled port number with the local index
    a_r11_gid: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && $past(rst_n)) |=> (!lk_hit ||
            lk_gid == {$past(port_id), lk_bank}));
endmodule

bind bank_decoder bank_decoder_chk #(.PORT_W(PORT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .port_id (port_id),
    .lk_req  (lk_req),
    .lk_done (lk_done),
    .lk_hit  (lk_hit),
    .lk_bank (lk_bank),
    .lk_gid  (lk_gid),
    .lk_base (lk_base),
    .lk_ilv  (lk_ilv),
    .lk_size (lk_size)
);

// File: tb/tb_bank_decoder.sv
module tb_bank_decoder;
    import bank_dec_pkg::*;

    localparam int PW = 5;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 cfg_we = 1'b0;
    logic [IDX_W-1:0]     cfg_sel = '0;
    logic [ENTRY_W-1:0]   cfg_data = '0;
    logic [PW-1:0]        port_id = '0;
    logic                 lk_req = 1'b0;
    logic [PA_W-1:0]      lk_addr = '0;
    logic                 lk_done, lk_hit;
    logic [IDX_W-1:0]     lk_bank;
    logic [PW+IDX_W-1:0]  lk_gid;
    logic [PA_W-1:0]      lk_base, lk_size;
    logic [LO_W:0]        lk_ilv;

    int checks = 0;
    int errors = 0;

    logic [ENTRY_W-1:0] model [NBANK];

    bank_decoder #(.PORT_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .port_id(port_id), .lk_req(lk_req),
        .lk_addr(lk_addr), .lk_done(lk_done), .lk_hit(lk_hit),
        .lk_bank(lk_bank), .lk_gid(lk_gid), .lk_base(lk_base),
        .lk_ilv(lk_ilv), .lk_size(lk_size)
    );

    always #10 clk = ~clk;

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic logic [ENTRY_W-1:0] mk(input logic en, input logic [11:0] udc,
        input logic [11:0] uval, input logic [3:0] ldc, input logic [3:0] lval);
        return {en, udc, uval, ldc, lval};
    endfunction

    function automatic int exp_ilv(input logic [3:0] ldc);
        case (ldc)
            4'h0: return 16;
            4'h8: return 8;
            4'hC: return 4;
            4'hE: return 2;
            default: return 1;
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [ENTRY_W-1:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = IDX_W'(idx); cfg_data = val;
        @(negedge clk);
        cfg_we = 1'b0;
        model[idx] = val;
    endtask

    task automatic lookup_check(input logic [PA_W-1:0] addr, input string tag);
        logic ehit; int ebank; logic [11:0] ud, uv; logic [3:0] ld, lv;
        logic [63:0] ebase, esize; int eilv;
        logic [11:0] ua; logic [3:0] la;
        ehit = 1'b0; ebank = 0; ebase = 0; esize = 0; eilv = 0;
        ua = addr[41:30]; la = addr[9:6];
        for (int b = NBANK - 1; b >= 0; b--) begin
            {ud, uv, ld, lv} = model[b][31:0];
            if (model[b][32] && (((ua ^ uv) & ~ud) == 0) && (((la ^ lv) & ~ld) == 0)) begin
                ehit = 1'b1; ebank = b;
            end
        end
        if (ehit) begin
            {ud, uv, ld, lv} = model[ebank][31:0];
            eilv  = exp_ilv(ld);
            ebase = 64'(uv & ~ud) << 30;
            esize = ((64'(ud & 12'h3FF) + 64'd1) << 30) / 64'(eilv);
        end
        @(negedge clk);
        lk_req = 1'b1; lk_addr = addr;
        @(negedge clk);
        lk_req = 1'b0;
        check(tag, "done", 64'(lk_done), 64'd1);
        check(tag, "hit", 64'(lk_hit), 64'(ehit));
        check(tag, "bank", 64'(lk_bank), 64'(ebank));
        check(tag, "gid", 64'(lk_gid), ehit ? 64'(port_id) * 4 + 64'(ebank) : 64'd0);
        check(tag, "base", 64'(lk_base), ebase);
        check(tag, "ilv", 64'(lk_ilv), 64'(eilv));
        check(tag, "size", 64'(lk_size), esize);
    endtask

    function automatic logic [3:0] pick_ldc(input int r);
        case (r % 7)
            0: return 4'hF; 1: return 4'hE; 2: return 4'hC;
            3: return 4'h8; 4: return 4'h0; default: return 4'($urandom);
        endcase
    endfunction

    initial begin
        void'($urandom(32'd2024));
        for (int b = 0; b < NBANK; b++) model[b] = '0;
        port_id = 5'd9;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "done idle", 64'(lk_done), 64'd0);
        lookup_check(42'h0, "R1");
        lookup_check({12'hFFF, 30'h3FFFFFFF}, "R1");
        // R2 / R3: disabled entry with all don't-care never claims
        wr(0, mk(1'b0, 12'hFFF, 12'h0, 4'hF, 4'h0));
        lookup_check(42'h123456789A, "R3");
        // R2: enabling it takes effect for the next lookup
        wr(0, mk(1'b1, 12'h003, 12'h005, 4'hF, 4'h0));
        lookup_check({12'h006, 30'h0}, "R2");
        // R4: upper bit outside the mask differs -> miss
        lookup_check({12'h00D, 30'h0}, "R4");
        // R5: lower field mismatch
        wr(1, mk(1'b1, 12'h0FF, 12'h100, 4'hC, 4'h1));
        lookup_check({12'h123, 20'h0, 4'h1, 6'h0}, "R5");
        lookup_check({12'h123, 20'h0, 4'h2, 6'h0}, "R5");
        // R6: overlap -> lowest index wins
        wr(2, mk(1'b1, 12'hFFF, 12'h0, 4'hF, 4'h0));
        lookup_check({12'h004, 30'h0}, "R6");
        lookup_check({12'h800, 30'h0}, "R6");
        // R7: miss with all disabled except nothing matching
        wr(2, mk(1'b0, 12'h0, 12'h0, 4'h0, 4'h0));
        lookup_check({12'h800, 30'h0}, "R7");
        // R8 interleave codes, R10 size with bits 10/11 set
        for (int k = 0; k < 6; k++) begin
            wr(3, mk(1'b1, 12'hC07, 12'h3F8, pick_ldc(k), 4'h0));
            lookup_check({12'h3F8, 30'h0}, "R8");
        end
        wr(3, mk(1'b1, 12'hFFF, 12'hABC, 4'h0, 4'h0));
        lookup_check({12'hABC, 30'h0}, "R10");
        // R9: base clears don't-care bits
        wr(3, mk(1'b1, 12'h00F, 12'hABC, 4'hF, 4'h0));
        lookup_check({12'hAB0, 30'h1}, "R9");
        // R11: port id change
        port_id = 5'd31;
        lookup_check({12'hAB5, 30'h0}, "R11");
        // R12: outputs hold without request
        repeat (2) @(negedge clk);
        check("R12", "done low", 64'(lk_done), 64'd0);
        check("R12", "hit held", 64'(lk_hit), 64'd1);
        // random phase
        for (int i = 0; i < 400; i++) begin
            logic [PA_W-1:0] a;
            int bsel;
            if (i % 25 == 0) begin
                for (int b = 0; b < NBANK; b++)
                    wr(b, mk(($urandom % 5) != 0, 12'($urandom) & 12'($urandom),
                             12'($urandom), pick_ldc(int'($urandom % 100)), 4'($urandom)));
                port_id = PW'($urandom);
            end
            a = {10'($urandom), 32'($urandom)};
            if (($urandom % 3) != 0) begin
                bsel = int'($urandom % NBANK);
                a[41:30] = model[bsel][19:8] ^ (12'($urandom) & model[bsel][31:20]);
                a[9:6]   = model[bsel][3:0]  ^ (4'($urandom) & model[bsel][7:4]);
            end
            lookup_check(a, (i % 2) ? "R4" : "R5");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule